// File: doc/BRIEF.md
# A/D converter control sequencer

This block is the digital side of an eight-input successive-approximation A/D converter on a small microcontroller. Software sees four byte-wide registers. The first is a control/status register that holds the input selector, the pad-mode code, a conversion-done flag and a START bit. The second is a clock-source register that holds the converter clock divider, a comparator enable and a test bit. The last two are read-only registers that return the 10-bit result.

A conversion is armed by toggling START. Writing START from 0 to 1 clears the converter and raises the done flag to its inactive (high) level. Writing START back to 0 launches the conversion. The block then divides the system clock, presents a trial code on `dac_code` and reads back the external comparator bit. It decides one result bit per converter-clock period, most significant bit first. When the tenth bit is decided, it stores the result and drives the done flag low.

The pad-mode code also drives eight analog-enable lines, filled from input 0 upward.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control bits 2..0 hold the input selector (000 selects input 0, 111 selects input 7). The selector is copied to `ch_sel` when a conversion starts, and `ch_sel` holds that value for the whole conversion even if the selector field is rewritten.
- R2: Control bits 5..3 hold a pad-mode code N. Code N sets `ana_en[N-1:0]` and clears all other bits, except code 7, which sets all eight bits.
- R3: After reset, the control register reads 0x40 (done flag 1, everything else 0). The clock-source register and both result registers read 0x00, and `ana_en`, `cmp_en` and `busy` are 0.
- R4: A write that changes START from 0 to 1 aborts any conversion and sets the done flag (control bit 6) to 1. While START stays 1, no conversion runs and the flag stays 1.
- R5: A write that changes START from 1 to 0 starts a conversion. The done flag reads 0 exactly 10·D clock cycles after that write's clock edge, where D is the divide ratio.
- R6: Clock-source bits 1..0 set D: 00 gives 2, 01 gives 8, 10 gives 32, and the reserved code 11 also gives 32.
- R7: Each decision keeps the trial bit when `cmp_in` is 1 and clears it when `cmp_in` is 0, starting from bit 9. With an ideal comparator (`cmp_in` = input ≥ `dac_code`), the result equals the input code. Register 2 returns result[9:2], and register 3 returns result[1:0] in its bits 1..0, with zeros above.
- R8: The clock-source register reads back bits 7, 2, 1 and 0 as written, and reads bits 6..3 as 0. `cmp_en` follows bit 2.
- R9: Control writes that leave START unchanged do not disturb a running conversion: its timing and result stay the same.
- R10: Writes to register addresses 2 and 3 have no effect on the values they return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 clock source, 2 result high, 3 result low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cmp_in | input | 1 | Comparator output: 1 when the analog input is at or above the trial code |
| dac_code | output | 10 | Current trial code for the DAC |
| ch_sel | output | 3 | Input selected for the running conversion |
| ana_en | output | 8 | Per-pad analog enables |
| cmp_en | output | 1 | Comparator enable |
| busy | output | 1 | Conversion in progress |

## Verification
A wrong bit decision or a misordered trial code leaves its mark in the stored result. The bench compares that result against the selected input, so an error shows on the first conversion. A divider or bit counter that is off by one moves the falling edge of the done flag, which the bench times to the exact cycle. A selector that leaks into a running conversion produces the result of the wrong input, so the bench rewrites the selector mid-conversion and checks the result. An abort that fails to clear the converter shows as the done flag dropping while START is still high.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cmp_in,
  output logic [9:0] dac_code,
  output logic [2:0] ch_sel,
  output logic [7:0] ana_en,
  output logic       cmp_en,
  output logic       busy
);

  logic [2:0] chan_q, pcr_q;
  logic       start_q, eocb_q;
  logic [1:0] div_sel_q;
  logic       cmp_en_q, test_q;
  logic       running;
  logic [4:0] cnt;
  logic [3:0] bitpos;
  logic [9:0] sar, result;
  logic [9:0] decided;

  wire wr_ctl  = wr_en && (addr == 2'd0);
  wire wr_clk  = wr_en && (addr == 2'd1);
  wire st_rise = wr_ctl &&  wdata[7] && !start_q;
  wire st_fall = wr_ctl && !wdata[7] &&  start_q;

  wire [4:0] div_last = (div_sel_q == 2'd0) ? 5'd1 :
                        (div_sel_q == 2'd1) ? 5'd7 : 5'd31;
  wire tick = running && (cnt == div_last);

  assign decided  = cmp_in ? sar : (sar & ~(10'd1 << bitpos));
  assign dac_code = sar;
  assign busy     = running;
  assign cmp_en   = cmp_en_q;
  assign ana_en   = (pcr_q == 3'd7) ? 8'hFF : ((8'd1 << pcr_q) - 8'd1);

  always_comb begin
    case (addr)
      2'd0:    rdata = {start_q, eocb_q, pcr_q, chan_q};
      2'd1:    rdata = {test_q, 4'd0, cmp_en_q, div_sel_q};
      2'd2:    rdata = result[9:2];
      default: rdata = {6'd0, result[1:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q    <= '0;
      pcr_q     <= '0;
      start_q   <= 1'b0;
      eocb_q    <= 1'b1;
      div_sel_q <= '0;
      cmp_en_q  <= 1'b0;
      test_q    <= 1'b0;
      running   <= 1'b0;
      cnt       <= '0;
      bitpos    <= '0;
      sar       <= '0;
      result    <= '0;
      ch_sel    <= '0;
    end else begin
      if (wr_ctl) begin
        chan_q  <= wdata[2:0];
        pcr_q   <= wdata[5:3];
        start_q <= wdata[7];
      end
      if (wr_clk) begin
        div_sel_q <= wdata[1:0];
        cmp_en_q  <= wdata[2];
        test_q    <= wdata[7];
      end
      if (st_rise) begin
        running <= 1'b0;
        eocb_q  <= 1'b1;
        sar     <= '0;
        cnt     <= '0;
      end else if (st_fall) begin
        running <= 1'b1;
        ch_sel  <= wdata[2:0];
        sar     <= 10'h200;
        bitpos  <= 4'd9;
        cnt     <= '0;
      end else if (running) begin
        cnt <= tick ? 5'd0 : cnt + 5'd1;
        if (tick) begin
          if (bitpos == 4'd0) begin
            result  <= decided;
            sar     <= decided;
            eocb_q  <= 1'b0;
            running <= 1'b0;
          end else begin
            sar    <= decided | (10'd1 << (bitpos - 4'd1));
            bitpos <= bitpos - 4'd1;
          end
        end
      end
    end
  end

  AST_START_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (eocb_q && !running)); // R4
  AST_CH_STABLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(ch_sel)); // R1
  AST_ANA_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((ana_en + 8'd1) & ana_en) == 8'd0); // R2
  AST_EOC_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eocb_q) |-> $past(running)); // R5
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6
  AST_RUN_EOC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> eocb_q); // R5

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [2:0] ch_sel;
  logic [7:0] ana_en;
  logic       cmp_en, busy;
  logic [9:0] vin [8];
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign cmp_in = (vin[ch_sel] >= dac_code);

  adc_seq_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cmp_in(cmp_in), .dac_code(dac_code), .ch_sel(ch_sel),
    .ana_en(ana_en), .cmp_en(cmp_en), .busy(busy));

  function automatic int div_of(input logic [1:0] c);
    return (c == 2'd0) ? 2 : (c == 2'd1) ? 8 : 32;
  endfunction

  function automatic logic [7:0] thermo(input logic [2:0] n);
    return (n == 3'd7) ? 8'hFF : 8'((9'd1 << n) - 9'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic convert(input logic [2:0] ch, input logic [1:0] dsel, input logic [2:0] pcr,
                         input bit mid_write, input bit abort);
    logic [7:0] d, hi, lo;
    int k;
    logic [2:0] other;
    wr(2'd1, {6'd0, dsel});
    wr(2'd0, {2'b10, pcr, ch});
    rd(2'd0, d);
    chk(d[6] == 1'b1, "R4 flag high after START rise", d[6], 1);
    if (abort) begin
      wr(2'd0, {2'b00, pcr, ch});
      repeat (15) @(negedge clk);
      wr(2'd0, {2'b10, pcr, ch});
      k = 0;
      for (int i = 0; i < 80; i++) begin
        rd(2'd0, d);
        if (d[6] == 1'b0 || busy) k++;
      end
      chk(k == 0, "R4 aborted and held while START=1", k, 0);
    end
    other = ch + 3'd3;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = {2'b00, pcr, ch};
    @(negedge clk);
    wr_en = 1'b0;
    k = 0;
    #1;
    while (rdata[6] && k < 2000) begin
      @(negedge clk);
      k++;
      if (mid_write && k == 3) begin
        wr_en = 1'b1; wdata = {2'b00, pcr, other};
      end else wr_en = 1'b0;
      #1;
    end
    chk(k == 10 * div_of(dsel), mid_write ? "R9 R5 R6 cycles to done" : "R5 R6 cycles to done",
        k, 10 * div_of(dsel));
    rd(2'd2, hi);
    rd(2'd3, lo);
    chk({hi, lo[1:0]} == vin[ch] && lo[7:2] == 6'd0,
        mid_write ? "R1 R9 R7 result ignores mid selector write" : "R7 result",
        {lo[7:2], hi, lo[1:0]}, vin[ch]);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) vin[i] = 10'(37 * i + 100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, d); chk(d == 8'h40, "R3 control reset", d, 8'h40);
    rd(2'd1, d); chk(d == 8'h00, "R3 clock reg reset", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R3 result high reset", d, 0);
    rd(2'd3, d); chk(d == 8'h00, "R3 result low reset", d, 0);
    chk(ana_en == 8'h00 && !cmp_en && !busy, "R3 outputs reset", {ana_en, cmp_en, busy}, 0);

    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk(d == 8'h87, "R8 clock reg readback", d, 8'h87);
    chk(cmp_en == 1'b1, "R8 cmp_en set", cmp_en, 1);
    wr(2'd1, 8'h78);
    rd(2'd1, d); chk(d == 8'h00 && !cmp_en, "R8 unused bits read 0", d, 0);

    for (int n = 0; n < 8; n++) begin
      wr(2'd0, {2'b00, 3'(n), 3'(n)});
      chk(ana_en == thermo(3'(n)), "R2 pad enables", ana_en, thermo(3'(n)));
      rd(2'd0, d); chk(d[2:0] == 3'(n), "R1 selector readback", d[2:0], n);
    end

    vin[5] = 10'h3FF; convert(3'd5, 2'd0, 3'd7, 1'b0, 1'b0);
    vin[0] = 10'h000; convert(3'd0, 2'd1, 3'd1, 1'b0, 1'b0);
    vin[7] = 10'h155; convert(3'd7, 2'd3, 3'd7, 1'b0, 1'b0);
    vin[2] = 10'h2AA; convert(3'd2, 2'd2, 3'd3, 1'b1, 1'b0);
    vin[4] = 10'h201; convert(3'd4, 2'd1, 3'd5, 1'b0, 1'b1);

    wr(2'd2, 8'hAA); wr(2'd3, 8'hFF);
    rd(2'd2, d); chk(d == 8'h80, "R10 result high write ignored", d, 8'h80);
    rd(2'd3, d); chk(d == 8'h01, "R10 result low write ignored", d, 8'h01);

    for (int t = 0; t < 14; t++) begin
      logic [2:0] ch;
      for (int i = 0; i < 8; i++) vin[i] = 10'($urandom);
      ch = 3'($urandom);
      convert(ch, 2'($urandom), 3'($urandom), bit'($urandom), (t % 5) == 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule